// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block lets a processor with an 11-bit address reach a memory of up to 32K words. Memory is treated as 32 pages of 1K words. The block keeps two 5-bit page registers. The lower register serves processor addresses whose bit 10 is 0, and the upper register serves addresses whose bit 10 is 1. Every physical address is the selected page number placed in front of the 10-bit offset within the page.

Two decoded strobes from the instruction decoder load the registers, one strobe for each bank. Both take a 5-bit page operand. When a bank register is written, the block also loads its Z register with a 12-bit instruction word. That word is the same bank-select opcode followed by the page the register held before the write. Software can save this word and execute it later to restore the bank. Reset gives lower = page 0 and upper = page 1, which is a plain flat 2K layout.

Top module: `mem_page_mapper`

## Requirements
- R1: After reset the lower page is 0, the upper page is 1 and the Z output is 0.
- R2: When cpuAddr[10] is 0, physAddr equals {lower page, cpuAddr[9:0]} in the same cycle.
- R3: When cpuAddr[10] is 1, physAddr equals {upper page, cpuAddr[9:0]} in the same cycle.
- R4: A cycle with setLowStb high loads pageOperand into the lower page from the next cycle on, and the upper page stays unchanged.
- R5: A cycle with setHighStb high (and setLowStb low) loads pageOperand into the upper page from the next cycle on, and the lower page stays unchanged.
- R6: At the edge where the lower page is written, zWord becomes {LOW_OPCODE (default 7'b0001011), old lower page}. The opcode is bits 11:5 and the page is bits 4:0.
- R7: At the edge where the upper page is written, zWord becomes {HIGH_OPCODE (default 7'b0001100), old upper page}, with the same field positions as R6.
- R8: If both strobes are high in one cycle, only the lower bank is written and Z takes the lower restore word. The upper page keeps its value.
- R9: In a cycle with neither strobe high, both pages and zWord keep their values.
- R10: Executing a captured zWord (its opcode selects the strobe and bits 4:0 give the operand) returns that bank to the page it held before the write that produced the word. This holds for both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setLowStb | input | 1 | Decoded strobe for the lower bank-select instruction |
| setHighStb | input | 1 | Decoded strobe for the upper bank-select instruction |
| pageOperand | input | 5 | Page number carried by the bank-select instruction |
| cpuAddr | input | 11 | Processor address; bit 10 picks the bank |
| physAddr | output | 15 | Physical memory address {page, offset} |
| zWord | output | 12 | Restore instruction word held in Z |

## Verification
A wrong page register shows up on physAddr in the very next cycle that addresses its half. It stays hidden, though, until that half is addressed. For this reason the bench alternates cpuAddr[10] from cycle to cycle, so each register is observed within two cycles. A wrong Z capture shows up on zWord right after the write edge. If Z took the new page instead of the old one, the round-trip restore would put the bank on the wrong page, and the next access would reveal it.

// File: rtl/page_map_pkg.sv
package page_map_pkg;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
  } bankCtrl_t;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/page_map_ctrl.sv
module page_map_ctrl
  import page_map_pkg::*;
(
  input  logic      setLowStb,
  input  logic      setHighStb,
  output bankCtrl_t ctrl
);

  // The lower bank wins when both strobes arrive together.
  always_comb begin
    ctrl.wrLow  = setLowStb;
    ctrl.wrHigh = setHighStb & ~setLowStb;
  end

endmodule

// File: rtl/page_map_datapath.sv
module page_map_datapath
  import page_map_pkg::*;
#(
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned OFFS_W = 10,
  parameter int unsigned OP_W = 7,
  parameter logic [OP_W-1:0] LOW_OPCODE = 7'b0001011,
  parameter logic [OP_W-1:0] HIGH_OPCODE = 7'b0001100,
  parameter logic [PAGE_W-1:0] LOW_RESET = 5'd0,
  parameter logic [PAGE_W-1:0] HIGH_RESET = 5'd1,
  localparam int unsigned ADDR_W = OFFS_W + 1,
  localparam int unsigned PHYS_W = PAGE_W + OFFS_W,
  localparam int unsigned WORD_W = OP_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtrl_t         ctrl,
  input  logic [PAGE_W-1:0] pageOperand,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [WORD_W-1:0] zWord
);

  logic [PAGE_W-1:0] pageReg [NUM_BANKS];
  logic [NUM_BANKS-1:0] wrEn;

  assign wrEn = {ctrl.wrHigh, ctrl.wrLow};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [PAGE_W-1:0] RST_VAL = (b == 0) ? LOW_RESET : HIGH_RESET;
    always_ff @(posedge clk) begin
      if (!rstN)        pageReg[b] <= RST_VAL;
      else if (wrEn[b]) pageReg[b] <= pageOperand;
    end
  end

  // Restore word captured from the page value before the update.
  always_ff @(posedge clk) begin
    if (!rstN)            zWord <= '0;
    else if (ctrl.wrLow)  zWord <= {LOW_OPCODE, pageReg[0]};
    else if (ctrl.wrHigh) zWord <= {HIGH_OPCODE, pageReg[1]};
  end

  assign physAddr = {pageReg[cpuAddr[OFFS_W]], cpuAddr[OFFS_W-1:0]};

  // R4
  low_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrLow |=> (pageReg[0] == $past(pageOperand)) && $stable(pageReg[1]));

  // R5
  high_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrHigh |=> (pageReg[1] == $past(pageOperand)) && $stable(pageReg[0]));

  // R6
  low_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrLow |=> zWord == {LOW_OPCODE, $past(pageReg[0])});

  // R7
  high_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrHigh |=> zWord == {HIGH_OPCODE, $past(pageReg[1])});

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrLow && !ctrl.wrHigh |=>
      $stable(zWord) && $stable(pageReg[0]) && $stable(pageReg[1]));

endmodule

// File: rtl/mem_page_mapper.sv
module mem_page_mapper
  import page_map_pkg::*;
#(
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned OFFS_W = 10,
  parameter int unsigned OP_W = 7,
  parameter logic [OP_W-1:0] LOW_OPCODE = 7'b0001011,
  parameter logic [OP_W-1:0] HIGH_OPCODE = 7'b0001100,
  parameter logic [PAGE_W-1:0] LOW_RESET = 5'd0,
  parameter logic [PAGE_W-1:0] HIGH_RESET = 5'd1,
  localparam int unsigned ADDR_W = OFFS_W + 1,
  localparam int unsigned PHYS_W = PAGE_W + OFFS_W,
  localparam int unsigned WORD_W = OP_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setLowStb,
  input  logic              setHighStb,
  input  logic [PAGE_W-1:0] pageOperand,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [WORD_W-1:0] zWord
);

  bankCtrl_t ctrl;

  page_map_ctrl u_ctrl (
    .setLowStb (setLowStb),
    .setHighStb(setHighStb),
    .ctrl      (ctrl)
  );

  page_map_datapath #(
    .PAGE_W     (PAGE_W),
    .OFFS_W     (OFFS_W),
    .OP_W       (OP_W),
    .LOW_OPCODE (LOW_OPCODE),
    .HIGH_OPCODE(HIGH_OPCODE),
    .LOW_RESET  (LOW_RESET),
    .HIGH_RESET (HIGH_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .pageOperand(pageOperand),
    .cpuAddr    (cpuAddr),
    .physAddr   (physAddr),
    .zWord      (zWord)
  );

  // R8
  dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    setLowStb && setHighStb |=> zWord[WORD_W-1:PAGE_W] == LOW_OPCODE);

endmodule

// File: tb/mem_page_mapper_bench.sv
`timescale 1ns/1ps
module mem_page_mapper_bench;

  localparam logic [6:0] LOW_OP = 7'b0001011;
  localparam logic [6:0] HIGH_OP = 7'b0001100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setLowStb = 1'b0;
  logic        setHighStb = 1'b0;
  logic [4:0]  pageOperand = '0;
  logic [10:0] cpuAddr = '0;
  logic [14:0] physAddr;
  logic [11:0] zWord;

  int checks = 0;
  int errors = 0;
  int lowM = 0;
  int highM = 1;
  int zM = 0;

  always #2.5 clk = ~clk;

  mem_page_mapper u_mem_page_mapper (
    .clk(clk), .rstN(rstN), .setLowStb(setLowStb), .setHighStb(setHighStb),
    .pageOperand(pageOperand), .cpuAddr(cpuAddr), .physAddr(physAddr), .zWord(zWord)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int expPhys(input logic [10:0] a);
    return ((a[10] ? highM : lowM) << 10) | int'(a[9:0]);
  endfunction

  // One clock: drive at the negedge, check physAddr combinationally, take the
  // posedge, update the model, then check zWord and the new mapping.
  task automatic step(input logic lo, input logic hi, input logic [4:0] pg,
                      input logic [10:0] a, input string tag);
    setLowStb = lo; setHighStb = hi; pageOperand = pg; cpuAddr = a;
    #0.5;
    check(a[10] ? "R3 physAddr" : "R2 physAddr", int'(physAddr), expPhys(a));
    @(posedge clk);
    if (lo) begin zM = (int'(LOW_OP) << 5) | lowM; lowM = pg; end
    else if (hi) begin zM = (int'(HIGH_OP) << 5) | highM; highM = pg; end
    @(negedge clk);
    setLowStb = 0; setHighStb = 0;
    check({tag, " zWord"}, int'(zWord), zM);
    cpuAddr = 11'h000; #0.5;
    check({tag, " lower page"}, int'(physAddr), expPhys(11'h000));
    cpuAddr = 11'h400; #0.5;
    check({tag, " upper page"}, int'(physAddr), expPhys(11'h400));
  endtask

  // Executes a saved restore word through the normal strobes.
  task automatic runZ(input logic [11:0] w, input string tag);
    step(w[11:5] == LOW_OP, w[11:5] == HIGH_OP, w[4:0], 11'h123, tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] saved;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    check("R1 zWord", int'(zWord), 0);
    cpuAddr = 11'h0ab; #0.5; check("R1 lower", int'(physAddr), 11'h0ab);
    cpuAddr = 11'h4cd; #0.5; check("R1 upper", int'(physAddr), (1 << 10) | 10'h0cd);
    @(negedge clk);
    // R2 / R3 / R9 idle with varied addresses
    for (int i = 0; i < 6; i++)
      step(0, 0, 5'(i * 7), 11'((i * 389) ^ (i[0] ? 11'h400 : 0)), "R9");
    step(1, 0, 5'd7, 11'h3ff, "R4 R6");
    step(0, 1, 5'd30, 11'h7ff, "R5 R7");
    step(1, 0, 5'd31, 11'h001, "R4 R6");
    step(0, 1, 5'd0, 11'h401, "R5 R7");
    step(1, 1, 5'd12, 11'h555, "R8");
    step(0, 0, 5'd3, 11'h2aa, "R9");
    // R10 lower round trip
    step(1, 0, 5'd20, 11'h010, "R10 lower set");
    saved = zWord;
    step(1, 0, 5'd9, 11'h410, "R10 lower other");
    runZ(saved, "R10 lower restore");
    check("R10 lower page", lowM, 12);
    // R10 upper round trip
    step(0, 1, 5'd17, 11'h020, "R10 upper set");
    saved = zWord;
    step(0, 1, 5'd25, 11'h420, "R10 upper other");
    runZ(saved, "R10 upper restore");
    check("R10 upper page", highM, 0);
    // sweep of pages, alternating banks
    for (int p = 0; p < 32; p++)
      step(p[0] ? 1'b0 : 1'b1, p[0], 5'(p), 11'(p * 61), "R4 R5 sweep");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule